// File: doc/BRIEF.md
# Receive FIFO Error-Count and Sticky Status Register

This block is the 16-bit status word of a serial receiver/transmitter pair that has a 16-entry receive queue. It keeps, for each byte in the queue, only the two error marks that came with it: a parity mark and a framing mark. The upper byte of the word holds two live 4-bit tallies of queued bytes with each kind of mark. The lower byte holds six sticky event flags and two read-only bits that show the marks of the byte at the head of the queue.

The sticky flags follow a read-then-clear discipline. A flag is cleared by a CPU write of 0 to its bit, and only if the CPU has already read that flag as 1 since the flag was last raised. A write of 1 never changes a flag. When a hardware event and a clearing write land in the same cycle, the event wins. The serial shifting, baud timing and interrupt logic sit outside this block and talk to it through single-cycle strobes.

Top module: `uerr_status_reg`

## Requirements
- R1: After reset the word reads 0x0060: bits 6 and 5 are 1, every other bit is 0, and the receive queue is empty.
- R2: Bits 15:12 give the number of queued bytes that carry a parity mark, and bits 11:8 give the number with a framing mark. An accepted push of a marked byte adds one, an accepted pop of a marked byte subtracts one, and both in the same cycle leave the tally unchanged.
- R3: Each tally is 4 bits wide and wraps, so it reads 0 when all 16 queued bytes carry that mark.
- R4: Bit 3 is the framing mark and bit 2 the parity mark of the byte at the head of the queue. Both read 0 when the queue is empty.
- R5: Bit 7 (receive error) is set by an accepted push whose byte has a parity or framing mark.
- R6: Event strobes set their flags on the next clock edge: transmit end to bit 6, transmit queue empty to bit 5, break to bit 4, receive queue full to bit 1, data ready to bit 0.
- R7: Writing 1 to any of bits 7, 6, 5, 4, 1, 0 leaves that flag unchanged.
- R8: Writing 0 to one of those bits clears the flag only if a CPU read has returned that flag as 1 since it was last set. Without such a read the flag keeps its value.
- R9: A set event, and any clearing write that had the earlier read, consumes that read. After this, a new read is required before a write of 0 clears the flag.
- R10: A set event in the same cycle as a qualifying clear write leaves the flag at 1.
- R11: CPU writes never change bits 15:8, 3 or 2.
- R12: A push while the queue holds 16 bytes and no pop is requested is dropped. A pop of an empty queue is ignored. With a push and a pop together, the pop is served first, so a full queue still takes the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_push | input | 1 | Received byte enters the queue |
| rx_push_pe | input | 1 | Parity mark of the pushed byte |
| rx_push_fe | input | 1 | Framing mark of the pushed byte |
| rx_pop | input | 1 | Head byte leaves the queue |
| tx_end_set | input | 1 | Transmit-end event strobe |
| tx_empty_set | input | 1 | Transmit-queue-empty event strobe |
| brk_set | input | 1 | Break-detected event strobe |
| rx_full_set | input | 1 | Receive-queue-full event strobe |
| rx_ready_set | input | 1 | Data-ready event strobe |
| cpu_rd | input | 1 | CPU reads the word this cycle |
| cpu_wr | input | 1 | CPU writes the word this cycle |
| cpu_wdata | input | 16 | CPU write data |
| rd_data | output | 16 | Current status word |

## Verification
The bench builds the block with its default queue depth of 16, which is the only depth that fits the fixed 4-bit tally fields. At that depth the bench can fill the queue completely with marked bytes, so the wrap of a tally to 0 and the drop of a 17th push can both be reached. Random traffic with a bounded push and pop mix keeps the queue moving through empty, partly filled and full. Random reads and writes in the same traffic exercise the read-then-clear rule against colliding set events.

// File: rtl/uerr_pkg.sv
package uerr_pkg;
  // Bit positions inside the status word (read by software decoders)
  localparam int BIT_ER     = 7;
  localparam int BIT_TEND   = 6;
  localparam int BIT_TEMPTY = 5;
  localparam int BIT_BRK    = 4;
  localparam int BIT_HFE    = 3;
  localparam int BIT_HPE    = 2;
  localparam int BIT_RFULL  = 1;
  localparam int BIT_RDY    = 0;

  localparam int NUM_STICKY = 6;

  // Sticky slot k -> bit position in the word
  function automatic int sticky_bit(input int k);
    case (k)
      0:       return BIT_ER;
      1:       return BIT_TEND;
      2:       return BIT_TEMPTY;
      3:       return BIT_BRK;
      4:       return BIT_RFULL;
      default: return BIT_RDY;
    endcase
  endfunction

  // Reset value per sticky slot
  function automatic logic sticky_rst(input int k);
    return (k == 1) || (k == 2);
  endfunction
endpackage

// File: rtl/uerr_rst_sync.sv
module uerr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/uerr_tag_fifo.sv
module uerr_tag_fifo #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic             push_pe,
  input  logic             push_fe,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             head_pe,
  output logic             head_fe,
  output logic [LVL_W-1:0] level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [1:0]       tag_q [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             empty, full;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (lvl_q == '0);
  assign full    = (lvl_q == FULL_LVL);
  assign pop_ok  = pop_req && !empty;
  assign push_ok = push_req && (!full || pop_req);

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    lvl_d    = lvl_q;
    if (pop_ok)  rd_ptr_d = ptr_next(rd_ptr_q);
    if (push_ok) wr_ptr_d = ptr_next(wr_ptr_q);
    if (push_ok && !pop_ok)      lvl_d = lvl_q + 1'b1;
    else if (pop_ok && !push_ok) lvl_d = lvl_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      lvl_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      lvl_q    <= lvl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tag_q[i] <= 2'b00;
    end else if (push_ok) begin
      tag_q[wr_ptr_q] <= {push_pe, push_fe};
    end
  end

  assign head_pe = !empty && tag_q[rd_ptr_q][1];
  assign head_fe = !empty && tag_q[rd_ptr_q][0];
  assign level   = lvl_q;

  // R12: occupancy never exceeds the depth
  p_level_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= FULL_LVL);

  // R12: a push into a full queue without a pop is dropped
  p_drop_when_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop_req) |=> (lvl_q == FULL_LVL) && $stable(wr_ptr_q));

  // R12: a pop of an empty queue changes nothing
  p_pop_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !push_req) |=> (lvl_q == '0) && $stable(rd_ptr_q));
endmodule

// File: rtl/uerr_err_count.sv
module uerr_err_count #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = inc ^ dec;

  always_comb begin
    cnt_d = cnt_q;
    if (inc) cnt_d = cnt_q + 1'b1;
    else     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R2: balanced or idle activity holds the tally
  p_hold_balanced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc == dec) |=> $stable(cnt_q));

  // R3: an increment from all-ones wraps to zero
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && (&cnt_q)) |=> (cnt_q == '0));
endmodule

// File: rtl/uerr_sticky_flag.sv
module uerr_sticky_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic rd_strobe,
  input  logic clr_req,
  output logic flag
);
  logic flag_q, flag_d;
  logic seen_q, seen_d;
  logic clr_hit;

  assign clr_hit = clr_req && seen_q;

  always_comb begin
    flag_d = flag_q;
    seen_d = seen_q;
    if (set_ev)       flag_d = 1'b1;
    else if (clr_hit) flag_d = 1'b0;
    if (set_ev || clr_hit)      seen_d = 1'b0;
    else if (rd_strobe && flag_q) seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= RST_VAL;
      seen_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      seen_q <= seen_d;
    end
  end

  assign flag = flag_q;

  // R10 / R6: a set event always leaves the flag at 1
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag_q);

  // R8: a flag only falls after a clearing write that followed a read
  p_clear_needs_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_d) |-> (clr_req && seen_q));

  // R9: after a set, the read mark is consumed
  p_set_consumes_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> !seen_q);
endmodule

// File: rtl/uerr_status_reg.sv
module uerr_status_reg #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_push,
  input  logic        rx_push_pe,
  input  logic        rx_push_fe,
  input  logic        rx_pop,
  input  logic        tx_end_set,
  input  logic        tx_empty_set,
  input  logic        brk_set,
  input  logic        rx_full_set,
  input  logic        rx_ready_set,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [15:0] cpu_wdata,
  output logic [15:0] rd_data
);
  import uerr_pkg::*;

  localparam int CNT_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int RD_W  = 8 + 2 * CNT_W;
  localparam int PE_HI = RD_W - 1;
  localparam int FE_HI = 8 + CNT_W - 1;

  logic             rst_n_i;
  logic             push_ok, pop_ok;
  logic             head_pe, head_fe;
  logic [LVL_W-1:0] level;
  logic [CNT_W-1:0] cnt_vec [2];
  logic [1:0]       cnt_inc, cnt_dec;
  logic [NUM_STICKY-1:0] set_vec, flag_vec;

  uerr_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  uerr_tag_fifo #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .push_req (rx_push),
    .pop_req  (rx_pop),
    .push_pe  (rx_push_pe),
    .push_fe  (rx_push_fe),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .head_pe  (head_pe),
    .head_fe  (head_fe),
    .level    (level)
  );

  // slot 0 tracks parity marks, slot 1 framing marks
  assign cnt_inc = {push_ok && rx_push_fe, push_ok && rx_push_pe};
  assign cnt_dec = {pop_ok && head_fe,     pop_ok && head_pe};

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    uerr_err_count #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n_i),
      .inc   (cnt_inc[g]),
      .dec   (cnt_dec[g]),
      .cnt   (cnt_vec[g])
    );
  end

  assign set_vec = {rx_ready_set, rx_full_set, brk_set, tx_empty_set, tx_end_set,
                    push_ok && (rx_push_pe || rx_push_fe)};

  for (genvar k = 0; k < NUM_STICKY; k++) begin : g_flag
    localparam int BP = sticky_bit(k);
    uerr_sticky_flag #(.RST_VAL(sticky_rst(k))) u_flag (
      .clk       (clk),
      .rst_n     (rst_n_i),
      .set_ev    (set_vec[k]),
      .rd_strobe (cpu_rd),
      .clr_req   (cpu_wr && !cpu_wdata[BP]),
      .flag      (flag_vec[k])
    );
  end

  always_comb begin
    rd_data = '0;
    rd_data[PE_HI -: CNT_W] = cnt_vec[0];
    rd_data[FE_HI -: CNT_W] = cnt_vec[1];
    rd_data[BIT_HFE] = head_fe;
    rd_data[BIT_HPE] = head_pe;
    for (int k = 0; k < NUM_STICKY; k++) rd_data[sticky_bit(k)] = flag_vec[k];
  end

  // R11: a write aimed at the read-only fields, with no queue traffic, leaves them alone
  p_ro_fields_r11: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cpu_wr && !rx_push && !rx_pop &&
     ((cpu_wdata[15:8] != rd_data[15:8]) || (cpu_wdata[3:2] != rd_data[3:2])))
    |=> $stable(rd_data[15:8]) && $stable(rd_data[3:2]));

  // R4: an empty queue shows no head marks
  p_empty_head_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (level == '0) |-> !rd_data[BIT_HFE] && !rd_data[BIT_HPE]);

  // R5: an accepted marked push raises the receive-error flag
  p_er_set_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (push_ok && (rx_push_pe || rx_push_fe)) |=> rd_data[BIT_ER]);
endmodule

// File: tb/uerr_status_reg_tb.sv
`timescale 1ns/1ps
module uerr_status_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_push, rx_push_pe, rx_push_fe, rx_pop;
  logic        tx_end_set, tx_empty_set, brk_set, rx_full_set, rx_ready_set;
  logic        cpu_rd, cpu_wr;
  logic [15:0] cpu_wdata;
  logic [15:0] rd_data;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // bench model
  int m_pe [16];
  int m_fe [16];
  int m_lvl;
  bit m_flag [6];
  bit m_seen [6];

  always #5 clk = ~clk;

  uerr_status_reg u_dut (
    .clk(clk), .rst_n(rst_n),
    .rx_push(rx_push), .rx_push_pe(rx_push_pe), .rx_push_fe(rx_push_fe), .rx_pop(rx_pop),
    .tx_end_set(tx_end_set), .tx_empty_set(tx_empty_set), .brk_set(brk_set),
    .rx_full_set(rx_full_set), .rx_ready_set(rx_ready_set),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .rd_data(rd_data)
  );

  // flag slot -> word bit, per R5/R6
  function automatic int fbit(input int k);
    case (k)
      0: return 7;
      1: return 6;
      2: return 5;
      3: return 4;
      4: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] exp_word();
    logic [15:0] w = '0;
    int pe = 0, fe = 0;
    for (int i = 0; i < m_lvl; i++) begin pe += m_pe[i]; fe += m_fe[i]; end
    w[15:12] = 4'(pe % 16);
    w[11:8]  = 4'(fe % 16);
    if (m_lvl > 0) begin w[3] = 1'(m_fe[0]); w[2] = 1'(m_pe[0]); end
    for (int k = 0; k < 6; k++) w[fbit(k)] = m_flag[k];
    return w;
  endfunction

  task automatic model_reset();
    m_lvl = 0;
    for (int i = 0; i < 16; i++) begin m_pe[i] = 0; m_fe[i] = 0; end
    for (int k = 0; k < 6; k++) begin m_flag[k] = (k == 1 || k == 2); m_seen[k] = 0; end
  endtask

  task automatic model_step();
    bit push_ok, pop_ok, clr;
    bit s [6];
    push_ok = rx_push && (m_lvl < 16 || rx_pop);
    pop_ok  = rx_pop && (m_lvl > 0);
    if (pop_ok) begin
      for (int i = 0; i < 15; i++) begin m_pe[i] = m_pe[i+1]; m_fe[i] = m_fe[i+1]; end
      m_lvl--;
    end
    if (push_ok) begin
      m_pe[m_lvl] = int'(rx_push_pe);
      m_fe[m_lvl] = int'(rx_push_fe);
      m_lvl++;
    end
    s[0] = push_ok && (rx_push_pe || rx_push_fe);
    s[1] = tx_end_set; s[2] = tx_empty_set; s[3] = brk_set;
    s[4] = rx_full_set; s[5] = rx_ready_set;
    for (int k = 0; k < 6; k++) begin
      clr = cpu_wr && !cpu_wdata[fbit(k)] && m_seen[k];
      if (s[k] || clr)             m_seen[k] = 0;
      else if (cpu_rd && m_flag[k]) m_seen[k] = 1;
      if (s[k])    m_flag[k] = 1;
      else if (clr) m_flag[k] = 0;
    end
  endtask

  task automatic idle_inputs();
    rx_push = 0; rx_push_pe = 0; rx_push_fe = 0; rx_pop = 0;
    tx_end_set = 0; tx_empty_set = 0; brk_set = 0; rx_full_set = 0; rx_ready_set = 0;
    cpu_rd = 0; cpu_wr = 0; cpu_wdata = '0;
  endtask

  task automatic chk_val(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock with the inputs set by the caller, then compare at the falling edge
  task automatic tick(input string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    idle_inputs();
    chk_val(req, rd_data, exp_word());
  endtask

  task automatic push(input bit pe, input bit fe, input string req);
    rx_push = 1; rx_push_pe = pe; rx_push_fe = fe; tick(req);
  endtask

  task automatic pop(input string req);
    rx_pop = 1; tick(req);
  endtask

  task automatic cpu_read(input string req);
    cpu_rd = 1; tick(req);
  endtask

  task automatic cpu_write(input logic [15:0] d, input string req);
    cpu_wr = 1; cpu_wdata = d; tick(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    idle_inputs();
    model_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk_val("R1 during reset", rd_data, 16'h0060);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk_val("R1 after reset", rd_data, 16'h0060);

    // R6 events
    brk_set = 1; tick("R6 break");
    chk_val("R6 break bit4", rd_data, 16'h0070);
    // R7 write ones after a read
    cpu_read("R7 read");
    cpu_write(16'hFFFF, "R7 write ones");
    chk_val("R7 unchanged", rd_data, 16'h0070);
    // R8 write 0 without a read
    rx_ready_set = 1; tick("R6 data ready");
    cpu_write(16'hFFFE, "R8 no read");
    chk_val("R8 kept without read", rd_data, 16'h0071);
    cpu_read("R8 read");
    cpu_write(16'hFFFE, "R8 clear");
    chk_val("R8 cleared after read", rd_data, 16'h0070);
    // R9 new set needs new read
    rx_ready_set = 1; tick("R9 re-set");
    cpu_write(16'hFFFE, "R9 stale read");
    chk_val("R9 kept", rd_data, 16'h0071);
    // R10 set and clear collide
    cpu_read("R10 read");
    rx_ready_set = 1; cpu_wr = 1; cpu_wdata = 16'hFFFE; tick("R10 collide");
    chk_val("R10 set wins", rd_data, 16'h0071);
    cpu_write(16'hFFFE, "R9 after collision");
    chk_val("R9 read consumed", rd_data, 16'h0071);
    // R6 remaining events
    rx_full_set = 1; tx_end_set = 1; tx_empty_set = 1; tick("R6 full/tx");
    chk_val("R6 bit1", rd_data, 16'h0073);

    // R2 / R5 tallies
    push(1, 0, "R2 push pe");
    chk_val("R5 er set", rd_data, 16'h10F7);
    push(1, 0, "R2 push pe");
    push(1, 1, "R2 push both");
    push(0, 1, "R2 push fe");
    chk_val("R2 tallies", rd_data[15:8], 16'h0032);
    chk_val("R4 head pe", 16'(rd_data[3:2]), 16'h0001);
    pop("R2 pop");
    pop("R2 pop");
    pop("R2 pop");
    chk_val("R4 head fe", 16'(rd_data[3:2]), 16'h0002);
    rx_push = 1; rx_push_pe = 1; rx_pop = 1; tick("R2 push+pop");
    chk_val("R2 swap", rd_data[15:8], 16'h0010);
    // R11 writes to read-only fields
    cpu_write(16'h0F08, "R11 write");
    chk_val("R11 ro held", 16'({rd_data[15:8], rd_data[3:2]}), 16'h0041);
    // drain and over-pop
    pop("R12 drain");
    pop("R12 pop empty");
    pop("R12 pop empty");
    chk_val("R4 empty head", 16'({rd_data[15:8], rd_data[3:2]}), 16'h0000);

    // R3 fill with parity-marked bytes
    for (int i = 0; i < 16; i++) push(1, 0, "R3 fill");
    chk_val("R3 wrap", 16'(rd_data[15:12]), 16'h0000);
    push(0, 1, "R12 push full");
    chk_val("R12 dropped", 16'(rd_data[11:8]), 16'h0000);
    rx_push = 1; rx_push_fe = 1; rx_pop = 1; tick("R12 push+pop full");
    chk_val("R12 swap at full", rd_data[15:8], 16'h00F1);
    for (int i = 0; i < 17; i++) pop("R12 drain");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      rx_push      = ($urandom % 100) < 45;
      rx_push_pe   = ($urandom % 100) < 25;
      rx_push_fe   = ($urandom % 100) < 25;
      rx_pop       = ($urandom % 100) < 40;
      tx_end_set   = ($urandom % 100) < 5;
      tx_empty_set = ($urandom % 100) < 5;
      brk_set      = ($urandom % 100) < 5;
      rx_full_set  = ($urandom % 100) < 5;
      rx_ready_set = ($urandom % 100) < 5;
      cpu_rd       = ($urandom % 100) < 30;
      cpu_wr       = ($urandom % 100) < 25;
      cpu_wdata    = 16'($urandom);
      tick("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule